// File: doc/BRIEF.md
# Page-Walk Permission Checker

This block sits beside a hardware page-table walker. For every table entry the walker fetches, it checks whether the pending access may proceed. The access is a read, a write or an instruction fetch, made at a given privilege level. The block judges each entry against the presence, writable, user-accessible and no-execute bits. While a walk is in progress it folds those bits into a combined permission set for the translation.

A walk opens with a start pulse. The walker then presents entries one per valid cycle, from the root level downwards, and flags the leaf with a last marker. Each accepted entry yields a registered pass/fail verdict. A failing entry also yields a structured fault code and the zero-based depth at which the walk failed, and the walk closes. A passing leaf yields the combined permissions one cycle later, and the walk closes.

Top module: `perm_walk_checker`

## Requirements
- R1: An entry whose bit 0 (present) is clear fails for every access kind and privilege level.
- R2: When `priv` equals 3 (user mode), an entry whose bit 2 (user-accessible) is clear fails. At any other privilege level, bit 2 does not affect the verdict.
- R3: When `acc_kind` is 1 (write), an entry whose bit 1 (writable) is clear fails. Code 0 is a read and code 3 is treated as a read, and for both, bit 1 does not affect the verdict.
- R4: When `acc_kind` is 2 (instruction fetch), an entry whose bit 63 (no-execute) is set fails.
- R5: An accepted entry raises `chk_valid` for exactly one cycle, in the cycle after it is presented. In that cycle `chk_ok` is high if the entry passes and low if it fails. `chk_ok` is low whenever `chk_valid` is low.
- R6: A failing entry raises `flt_valid` in the same cycle as its `chk_valid`. At that point `flt_code` holds: bit 0 = the entry's present bit, bit 1 = write access, bit 2 = user mode, bit 3 = reserved (0), bit 4 = instruction fetch. `flt_level` holds the zero-based position of the entry within the walk. Both fields keep their values until the next fault.
- R7: The combined permission set is formed across all entries of the walk. `res_write` is the AND of bit 1 over those entries, `res_user` is the AND of bit 2, and `res_noexec` is the OR of bit 63.
- R8: A passing entry presented with `ent_last` high raises `res_valid` for one cycle, in the cycle after it is presented, together with the R7 values. Those values hold until the next result. A failing leaf produces no `res_valid`.
- R9: Once a walk closes, whether through a fault or through an accepted leaf, entries are ignored until the next `walk_start`. The same applies between reset and the first `walk_start`. An ignored entry produces no `chk_valid`, `flt_valid` or `res_valid`, and does not disturb the held fault or result fields.
- R10: `walk_start` resets the level count to 0 and the accumulators to writable = 1, user = 1, no-execute = 0. An entry presented in the same cycle as `walk_start` is ignored.
- R11: During and directly after reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| walk_start | input | 1 | Opens a new walk and clears accumulators |
| ent_valid | input | 1 | An entry is presented this cycle |
| ent_data | input | ENTRY_W | Page-table entry word |
| ent_last | input | 1 | The presented entry is the leaf |
| acc_kind | input | 2 | 0 read, 1 write, 2 fetch, 3 read |
| priv | input | PRIV_W | Current privilege level |
| chk_valid | output | 1 | Per-entry verdict valid |
| chk_ok | output | 1 | Entry passed |
| flt_valid | output | 1 | Fault reported this cycle |
| flt_code | output | 5 | Fault flags {fetch, reserved, user, write, present} |
| flt_level | output | LVL_W | Zero-based depth of the failing entry |
| res_valid | output | 1 | Combined permissions valid |
| res_write | output | 1 | Combined writable |
| res_user | output | 1 | Combined user-accessible |
| res_noexec | output | 1 | Combined no-execute |

## Verification
The bench keeps the 64-bit entry so that the no-execute bit sits at its real position. It narrows the level counter to two bits, which makes four-level walks use every depth code, so a fault at the deepest level reports the largest value the counter can hold. Directed walks cover each fault cause at each depth, entries offered while the walk is closed, a start pulse that coincides with an entry, and the treatment of access code 3 as a read. Several hundred randomized walks mix privilege levels and access kinds.

// File: rtl/perm_walk_checker.sv
module perm_walk_checker #(
  parameter int ENTRY_W   = 64,
  parameter int LVL_W     = 3,
  parameter int PRIV_W    = 2,
  parameter int USER_PRIV = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               walk_start,
  input  logic               ent_valid,
  input  logic [ENTRY_W-1:0] ent_data,
  input  logic               ent_last,
  input  logic [1:0]         acc_kind,
  input  logic [PRIV_W-1:0]  priv,
  output logic               chk_valid,
  output logic               chk_ok,
  output logic               flt_valid,
  output logic [4:0]         flt_code,
  output logic [LVL_W-1:0]   flt_level,
  output logic               res_valid,
  output logic               res_write,
  output logic               res_user,
  output logic               res_noexec
);
  localparam int P_BIT  = 0;
  localparam int RW_BIT = 1;
  localparam int US_BIT = 2;
  localparam int NX_BIT = ENTRY_W - 1;
  localparam logic [1:0] ACC_WR = 2'd1;
  localparam logic [1:0] ACC_EX = 2'd2;

  logic             walk_open;
  logic [LVL_W-1:0] lvl;
  logic             acc_w, acc_u, acc_nx;

  wire unused_mid = ^ent_data[NX_BIT-1:US_BIT+1];

  wire take    = walk_open & ent_valid & ~walk_start;
  wire is_user = (priv == PRIV_W'(USER_PRIV));
  wire is_wr   = (acc_kind == ACC_WR);
  wire is_ex   = (acc_kind == ACC_EX);
  wire e_p     = ent_data[P_BIT];
  wire e_rw    = ent_data[RW_BIT];
  wire e_us    = ent_data[US_BIT];
  wire e_nx    = ent_data[NX_BIT];
  wire deny    = ~e_p | (is_user & ~e_us) | (is_wr & ~e_rw) | (is_ex & e_nx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      walk_open  <= 1'b0;
      lvl        <= '0;
      acc_w      <= 1'b1;
      acc_u      <= 1'b1;
      acc_nx     <= 1'b0;
      chk_valid  <= 1'b0;
      chk_ok     <= 1'b0;
      flt_valid  <= 1'b0;
      flt_code   <= '0;
      flt_level  <= '0;
      res_valid  <= 1'b0;
      res_write  <= 1'b0;
      res_user   <= 1'b0;
      res_noexec <= 1'b0;
    end else begin
      chk_valid <= take;
      chk_ok    <= take & ~deny;
      flt_valid <= take & deny;
      res_valid <= take & ~deny & ent_last;
      if (walk_start) begin
        walk_open <= 1'b1;
        lvl       <= '0;
        acc_w     <= 1'b1;
        acc_u     <= 1'b1;
        acc_nx    <= 1'b0;
      end else if (take) begin
        lvl    <= lvl + 1'b1;
        acc_w  <= acc_w & e_rw;
        acc_u  <= acc_u & e_us;
        acc_nx <= acc_nx | e_nx;
        if (deny) begin
          walk_open <= 1'b0;
          flt_code  <= {is_ex, 1'b0, is_user, is_wr, e_p};
          flt_level <= lvl;
        end else if (ent_last) begin
          walk_open  <= 1'b0;
          res_write  <= acc_w & e_rw;
          res_user   <= acc_u & e_us;
          res_noexec <= acc_nx | e_nx;
        end
      end
    end
  end

  assert_ok_needs_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    chk_ok |-> chk_valid);

  assert_fault_is_failed_check_R6: assert property (@(posedge clk) disable iff (!rst_n)
    flt_valid |-> (chk_valid && !chk_ok));

  assert_failed_check_faults_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid && !chk_ok) |-> flt_valid);

  assert_result_only_on_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (chk_valid && chk_ok));

  assert_single_outcome_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({res_valid, flt_valid}));

  assert_quiet_after_fault_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flt_valid |=> !chk_valid);

  assert_quiet_after_leaf_R9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !chk_valid);

  assert_start_drops_entry_R10: assert property (@(posedge clk) disable iff (!rst_n)
    walk_start |=> !chk_valid);
endmodule

// File: tb/sim_perm_walk_checker.sv
module sim_perm_walk_checker;
  localparam int EW = 64;
  localparam int LW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          walk_start = 1'b0;
  logic          ent_valid = 1'b0;
  logic [EW-1:0] ent_data = '0;
  logic          ent_last = 1'b0;
  logic [1:0]    acc_kind = 2'd0;
  logic [1:0]    priv = 2'd0;
  logic          chk_valid, chk_ok, flt_valid, res_valid, res_write, res_user, res_noexec;
  logic [4:0]    flt_code;
  logic [LW-1:0] flt_level;

  always #10 clk = ~clk;

  perm_walk_checker #(.ENTRY_W(EW), .LVL_W(LW)) u0 (
    .clk(clk), .rst_n(rst_n), .walk_start(walk_start), .ent_valid(ent_valid),
    .ent_data(ent_data), .ent_last(ent_last), .acc_kind(acc_kind), .priv(priv),
    .chk_valid(chk_valid), .chk_ok(chk_ok), .flt_valid(flt_valid), .flt_code(flt_code),
    .flt_level(flt_level), .res_valid(res_valid), .res_write(res_write),
    .res_user(res_user), .res_noexec(res_noexec));

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  // Reference model: updated on each edge from the inputs held steady across it.
  bit       m_open = 0;
  int       m_lvl = 0;
  bit       m_w = 1, m_u = 1, m_nx = 0;
  bit       e_cv = 0, e_ok = 0, e_fv = 0, e_rv = 0, e_rw = 0, e_ru = 0, e_rnx = 0;
  bit [4:0] e_code = 0;
  int       e_flv = 0;

  always @(posedge clk) begin
    bit tk, bad;
    if (!rst_n) begin
      m_open = 0; m_lvl = 0; m_w = 1; m_u = 1; m_nx = 0;
      e_cv = 0; e_ok = 0; e_fv = 0; e_rv = 0; e_rw = 0; e_ru = 0; e_rnx = 0;
      e_code = 0; e_flv = 0;
    end else begin
      tk = m_open && ent_valid && !walk_start;
      bad = 0;
      if (!ent_data[0]) bad = 1;                         // R1
      if (priv == 2'd3 && !ent_data[2]) bad = 1;         // R2
      if (acc_kind == 2'd1 && !ent_data[1]) bad = 1;     // R3
      if (acc_kind == 2'd2 && ent_data[63]) bad = 1;     // R4
      e_cv = tk;
      e_ok = tk && !bad;
      e_fv = tk && bad;
      e_rv = tk && !bad && ent_last;
      if (tk) begin
        m_w = m_w & ent_data[1];
        m_u = m_u & ent_data[2];
        m_nx = m_nx | ent_data[63];
        if (bad) begin
          e_code = {acc_kind == 2'd2, 1'b0, priv == 2'd3, acc_kind == 2'd1, ent_data[0]};
          e_flv = m_lvl % 4;
          m_open = 0;
        end else if (ent_last) begin
          e_rw = m_w; e_ru = m_u; e_rnx = m_nx;
          m_open = 0;
        end
        m_lvl = m_lvl + 1;
      end
      if (walk_start) begin
        m_open = 1; m_lvl = 0; m_w = 1; m_u = 1; m_nx = 0;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input string got, input string exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at %0t: got %s expected %s", tag, $time, got, exp);
    end
  endtask

  always @(posedge clk) begin
    #5;
    if (!finished) begin
      check(chk_valid === e_cv && chk_ok === e_ok, "R5 verdict (R1 R2 R3 R4 R9 R10 R11)",
            $sformatf("v=%b ok=%b", chk_valid, chk_ok), $sformatf("v=%b ok=%b", e_cv, e_ok));
      check(flt_valid === e_fv && flt_code === e_code && int'(flt_level) == e_flv,
            "R6 fault (R11)",
            $sformatf("v=%b code=%b lvl=%0d", flt_valid, flt_code, flt_level),
            $sformatf("v=%b code=%b lvl=%0d", e_fv, e_code, e_flv));
      check(res_valid === e_rv && res_write === e_rw && res_user === e_ru && res_noexec === e_rnx,
            "R7 R8 result (R11)",
            $sformatf("v=%b w=%b u=%b nx=%b", res_valid, res_write, res_user, res_noexec),
            $sformatf("v=%b w=%b u=%b nx=%b", e_rv, e_rw, e_ru, e_rnx));
    end
  end

  function automatic logic [63:0] mk(input bit p, input bit rw, input bit us, input bit nx);
    logic [63:0] d;
    d = {$urandom(), $urandom()};
    d[0] = p; d[1] = rw; d[2] = us; d[63] = nx;
    return d;
  endfunction

  task automatic start();
    @(negedge clk);
    walk_start = 1; ent_valid = 0; ent_last = 0;
  endtask

  task automatic ent(input logic [63:0] d, input logic [1:0] k, input logic [1:0] p, input bit last);
    @(negedge clk);
    walk_start = 0; ent_valid = 1; ent_data = d; acc_kind = k; priv = p; ent_last = last;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      walk_start = 0; ent_valid = 0; ent_last = 0;
    end
  endtask

  task automatic finish_run();
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);                 // R11: outputs compared while in reset
    rst_n = 1;
    // R9: entries before any start are ignored
    ent(mk(1,1,1,0), 2'd0, 2'd3, 1);
    idle(2);
    // R7 R8: four-level passing walk, NX set at level 1 ORs in, RW cleared at level 2 ANDs out
    start();
    ent(mk(1,1,1,0), 2'd0, 2'd3, 0);
    ent(mk(1,1,1,1), 2'd0, 2'd3, 0);
    ent(mk(1,0,1,0), 2'd0, 2'd3, 0);
    ent(mk(1,1,1,0), 2'd0, 2'd3, 1);
    idle(1);
    // R9: entry after leaf ignored
    ent(mk(0,0,0,0), 2'd1, 2'd3, 0);
    idle(1);
    // R2: user-mode access to supervisor entry at level 2
    start();
    ent(mk(1,1,1,0), 2'd0, 2'd3, 0);
    ent(mk(1,1,1,0), 2'd0, 2'd3, 0);
    ent(mk(1,1,0,0), 2'd0, 2'd3, 0);
    ent(mk(1,1,1,0), 2'd0, 2'd3, 1);         // R9: ignored after fault
    idle(1);
    // R2: supervisor passes through non-user entries
    start();
    ent(mk(1,1,0,0), 2'd1, 2'd0, 0);
    ent(mk(1,1,0,0), 2'd1, 2'd0, 1);
    idle(1);
    // R3: write to read-only leaf at level 3
    start();
    ent(mk(1,1,1,0), 2'd1, 2'd3, 0);
    ent(mk(1,1,1,0), 2'd1, 2'd3, 0);
    ent(mk(1,1,1,0), 2'd1, 2'd3, 0);
    ent(mk(1,0,1,0), 2'd1, 2'd3, 1);
    idle(1);
    // R3: code 3 and code 0 reads ignore bit 1
    start();
    ent(mk(1,0,1,0), 2'd3, 2'd3, 0);
    ent(mk(1,0,1,1), 2'd0, 2'd3, 1);
    idle(1);
    // R4: fetch from no-execute root
    start();
    ent(mk(1,1,1,1), 2'd2, 2'd1, 0);
    idle(1);
    // R1: not-present at level 1 on read
    start();
    ent(mk(1,1,1,0), 2'd0, 2'd2, 0);
    ent(mk(0,1,1,0), 2'd0, 2'd2, 0);
    idle(1);
    // R10: entry coinciding with start is ignored, then a clean leaf
    @(negedge clk);
    walk_start = 1; ent_valid = 1; ent_data = mk(0,0,0,1); acc_kind = 2'd2; priv = 2'd3; ent_last = 1;
    ent(mk(1,1,1,0), 2'd2, 2'd3, 1);
    idle(1);
    // R8: failing leaf gives no result
    start();
    ent(mk(1,1,1,1), 2'd2, 2'd0, 1);
    idle(2);
    // Randomized walks across all requirements
    for (int w = 0; w < 400; w++) begin
      int depth;
      depth = 1 + ($urandom() % 4);
      start();
      for (int l = 0; l < depth; l++) begin
        ent(mk(($urandom() % 10) != 0, ($urandom() % 4) != 0, ($urandom() % 4) != 0,
               ($urandom() % 4) == 0),
            2'($urandom()), 2'($urandom()), l == depth - 1);
        if (($urandom() % 5) == 0) idle(1);
      end
      idle($urandom() % 3);
    end
    idle(3);
    finish_run();
  end
endmodule